// File: doc/BRIEF.md
# Pipelined SRAM Write and Deselect Control

This block is the control path of a synchronous pipelined static RAM. Every control, address and data input is captured on the rising clock edge. Three chip enables with mixed polarities must all be active for a cycle to count. A global write strobe and a byte-write strobe with per-lane selects are decoded into per-lane write strobes. A small internal array of four 9-bit lanes holds the data so that the control behaviour can be observed at the ports.

Reads are pipelined. The array is read on the edge that follows capture, and the result is held in an output register. A separate drive-enable output stands in for the tri-state data bus. It follows a two-stage select pipeline, so a read that is already in flight is still driven after the part is deselected. The same pipeline also keeps the bus undriven for the first clock of a read that follows a deselected cycle. The output enable acts on the drive-enable combinationally.

Top module: `sram_pipe_ctrl`

## Requirements
- R1: A cycle is selected only when `ce0_ni` is low, `ce1_i` is high and `ce2_ni` is low at the rising edge. A write attempted while any one of the three is inactive leaves the array unchanged and does not drive the bus.
- R2: When the part is selected, `gw_ni` is high and `bwe_ni` is low, lane b is written if and only if `bsel_ni[b]` is low. Lane b occupies data bits [9b+8:9b].
- R3: When the part is selected and `gw_ni` is low, all four lanes are written, whatever the values of `bwe_ni` and `bsel_ni`.
- R4: When the part is selected, `gw_ni` is high, `bwe_ni` is low and no lane select is low, the cycle is a write of no lanes. The array is unchanged and the bus is not driven.
- R5: A selected cycle with `gw_ni` and `bwe_ni` both high is a read. If it is captured at edge E, its data appears on `rdata_o` and `drive_o` rises after edge E+1, provided `oe_ni` is low.
- R6: A write captured at edge E becomes visible to a read captured at edge E+1.
- R7: A read still in flight when a deselect is captured stays driven. `drive_o` falls after the edge that follows the deselect capture.
- R8: In the first clock of a read that follows a deselected cycle, `drive_o` stays low.
- R9: `oe_ni` high forces `drive_o` low at once, without waiting for a clock edge. Bringing `oe_ni` low again restores the drive at once.
- R10: In the clock after a write is captured, the bus is not driven.
- R11: While reset is asserted, and right after it is released, `drive_o` is low and `rdata_o` is zero.
- R12: `rdata_o` keeps its last read value through write cycles and deselected cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce0_ni | input | 1 | Chip enable, active low |
| ce1_i | input | 1 | Chip enable, active high |
| ce2_ni | input | 1 | Chip enable, active low |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | LANES*LANE_W | Write data, lane b at [9b+8:9b] |
| gw_ni | input | 1 | Global write, active low, writes all lanes |
| bwe_ni | input | 1 | Byte-write enable, active low |
| bsel_ni | input | LANES | Per-lane write selects, active low |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | LANES*LANE_W | Registered read data |
| drive_o | output | 1 | Data bus drive enable (stands in for tri-state) |

## Verification
The bench targets the moment a deselect is captured while a read is still in flight. A design with only one pipeline stage would drop the drive too early and lose that read. It also checks the first clock after a deselected cycle, where a design that gated only on the output enable would drive stale data. The write decode is tested with the global write alongside a conflicting byte-select pattern, and with the byte-write enable active but no lane selected. A wrong decode there shows up as corrupted lanes, or as a phantom read that drives the bus. The bench also reads immediately after a write and checks that the read data is held across non-read cycles, which catches a missing write-commit ordering and an output register that updates on every cycle.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/sram_ctl_decode.sv
module sram_ctl_decode
  import sram_ctl_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             ce0_ni,
  input  logic             ce1_i,
  input  logic             ce2_ni,
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] bsel_ni,
  output op_e              op_o,
  output logic [LANES-1:0] strb_o
);
  logic sel;
  assign sel = ~ce0_ni & ce1_i & ~ce2_ni;

  always_comb begin
    op_o   = OP_IDLE;
    strb_o = '0;
    if (sel) begin
      if (!gw_ni) begin
        // global write wins over byte selects
        op_o   = OP_WRITE;
        strb_o = '1;
      end else if (!bwe_ni) begin
        op_o   = OP_WRITE;
        strb_o = ~bsel_ni;
      end else begin
        op_o = OP_READ;
      end
    end
  end
endmodule

// File: rtl/sram_ctl_req_stage.sv
module sram_ctl_req_stage
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic [LANES-1:0]  strb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output op_e               op_o,
  output logic [LANES-1:0]  strb_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o    <= OP_IDLE;
      strb_o  <= '0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else begin
      op_o    <= op_i;
      strb_o  <= strb_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end
endmodule

// File: rtl/sram_ctl_lane_array.sv
module sram_ctl_lane_array #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [LANES-1:0]  strb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (wr_en_i && strb_i[g]) mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = mem[addr_i];
  end
endmodule

// File: rtl/sram_ctl_out_stage.sv
module sram_ctl_out_stage #(
  parameter int DATA_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o
);
  logic drv_q;

  // second stage of the select pipeline: drive follows the in-flight read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_q   <= 1'b0;
      rdata_o <= '0;
    end else begin
      drv_q <= rd_i;
      if (rd_i) rdata_o <= rdata_i;
    end
  end

  assign drive_o = drv_q & ~oe_ni;
endmodule

// File: rtl/sram_pipe_ctrl.sv
module sram_pipe_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce0_ni,
  input  logic              ce1_i,
  input  logic              ce2_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              gw_ni,
  input  logic              bwe_ni,
  input  logic [LANES-1:0]  bsel_ni,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o
);
  op_e               dec_op;
  logic [LANES-1:0]  dec_strb;
  op_e               req_op_q;
  logic [LANES-1:0]  req_strb_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic [DATA_W-1:0] arr_rdata;

  sram_ctl_decode #(.LANES(LANES)) u_decode (
    .ce0_ni (ce0_ni),
    .ce1_i  (ce1_i),
    .ce2_ni (ce2_ni),
    .gw_ni  (gw_ni),
    .bwe_ni (bwe_ni),
    .bsel_ni(bsel_ni),
    .op_o   (dec_op),
    .strb_o (dec_strb)
  );

  sram_ctl_req_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (dec_op),
    .strb_i (dec_strb),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .op_o   (req_op_q),
    .strb_o (req_strb_q),
    .addr_o (req_addr_q),
    .wdata_o(req_wdata_q)
  );

  sram_ctl_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i  (clk_i),
    .wr_en_i(req_op_q == OP_WRITE),
    .strb_i (req_strb_q),
    .addr_i (req_addr_q),
    .wdata_i(req_wdata_q),
    .rdata_o(arr_rdata)
  );

  sram_ctl_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (req_op_q == OP_READ),
    .rdata_i(arr_rdata),
    .oe_ni  (oe_ni),
    .rdata_o(rdata_o),
    .drive_o(drive_o)
  );
endmodule

// File: rtl/sram_pipe_ctrl_chk.sv
module sram_pipe_ctrl_chk #(
  parameter int LANES  = 4,
  parameter int DATA_W = 36
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce0_ni,
  input logic              ce1_i,
  input logic              ce2_ni,
  input logic              gw_ni,
  input logic              bwe_ni,
  input logic [LANES-1:0]  bsel_ni,
  input logic              oe_ni,
  input logic [DATA_W-1:0] rdata_o,
  input logic              drive_o,
  input logic [LANES-1:0]  strb_q
);
  logic sel_w, rd_w, wr_w;
  assign sel_w = !ce0_ni && ce1_i && !ce2_ni;
  assign rd_w  = sel_w && gw_ni && bwe_ni;
  assign wr_w  = sel_w && !(gw_ni && bwe_ni);

  assert_desel_no_strb_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_w |=> strb_q == '0);
  assert_byte_lanes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_w && gw_ni && !bwe_ni |=> strb_q == ~$past(bsel_ni));
  assert_global_all_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_w && !gw_ni |=> strb_q == '1);
  assert_read_drive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_w |=> ##1 (drive_o || oe_ni));
  assert_desel_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_w |=> ##1 !drive_o);
  assert_first_read_masked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!sel_w) && rd_w |=> !drive_o);
  assert_oe_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !drive_o);
  assert_write_no_drive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_w |=> ##1 !drive_o);
  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_w |=> ##1 $stable(rdata_o));
endmodule

bind sram_pipe_ctrl sram_pipe_ctrl_chk #(.LANES(LANES), .DATA_W(DATA_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ce0_ni (ce0_ni),
  .ce1_i  (ce1_i),
  .ce2_ni (ce2_ni),
  .gw_ni  (gw_ni),
  .bwe_ni (bwe_ni),
  .bsel_ni(bsel_ni),
  .oe_ni  (oe_ni),
  .rdata_o(rdata_o),
  .drive_o(drive_o),
  .strb_q (req_strb_q)
);

// File: tb/sram_pipe_ctrl_test.sv
module sram_pipe_ctrl_test;
  localparam int AW = 4;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce0_n = 1'b0, ce1 = 1'b0, ce2_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
  logic [3:0]    bsel_n = 4'hF;
  logic [DW-1:0] rdata;
  logic          drive;

  sram_pipe_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .ce0_ni(ce0_n), .ce1_i(ce1), .ce2_ni(ce2_n),
    .addr_i(addr), .wdata_i(wdata), .gw_ni(gw_n), .bwe_ni(bwe_n),
    .bsel_ni(bsel_n), .oe_ni(oe_n), .rdata_o(rdata), .drive_o(drive)
  );

  always #10 clk = ~clk;

  typedef struct {
    int            due;
    logic          exp_drv;
    logic [DW-1:0] exp_data;
    string         tag;
  } item_t;

  item_t         sb[$];
  item_t         it;
  int            cyc = 0;
  int            n_cmp = 0, n_bad = 0;
  bit            done = 1'b0;
  logic [DW-1:0] ref_mem [16];
  logic [DW-1:0] last_rd = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: compares results as they come due
  always @(negedge clk) begin
    if (rst_n) begin
      while (sb.size() > 0 && sb[0].due == cyc) begin
        it = sb.pop_front();
        chk(it.tag, "drive", {35'd0, drive}, {35'd0, it.exp_drv});
        chk(it.tag, "rdata", rdata, it.exp_data);
      end
    end
  end

  // driver: one operation per clock, expected item pushed to the scoreboard
  task automatic step(bit c0n, bit c1, bit c2n, bit gwn, bit bwen, logic [3:0] bsn,
                      logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    item_t e;
    bit sel, is_rd;
    @(negedge clk); #1;
    ce0_n = c0n; ce1 = c1; ce2_n = c2n; gw_n = gwn; bwe_n = bwen;
    bsel_n = bsn; addr = a; wdata = d;
    sel   = !c0n && c1 && !c2n;
    is_rd = sel && gwn && bwen;
    if (sel && !is_rd) begin
      for (int b = 0; b < 4; b++)
        if (!gwn || !bsn[b]) ref_mem[a][b*9 +: 9] = d[b*9 +: 9];
    end
    if (is_rd) last_rd = ref_mem[a];
    e.due = cyc + 2; e.exp_drv = is_rd; e.exp_data = last_rd; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic rd(logic [AW-1:0] a, string tag);
    step(0, 1, 0, 1, 1, 4'hF, a, '0, tag);
  endtask
  task automatic gwr(logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    step(0, 1, 0, 0, 1, 4'hF, a, d, tag);
  endtask
  task automatic bwr(logic [AW-1:0] a, logic [DW-1:0] d, logic [3:0] bsn, string tag);
    step(0, 1, 0, 1, 0, bsn, a, d, tag);
  endtask
  task automatic idle(string tag);
    step(0, 0, 0, 1, 1, 4'hF, '0, '0, tag);
  endtask

  // R9: output enable acts without a clock edge
  task automatic oe_probe();
    @(negedge clk); #2;
    oe_n = 1'b1; #1;
    chk("R9", "drive oe high", {35'd0, drive}, 36'd0);
    oe_n = 1'b0; #1;
    chk("R9", "drive oe low", {35'd0, drive}, 36'd1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (6000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "drive in reset", {35'd0, drive}, 36'd0);
    chk("R11", "rdata in reset", rdata, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "drive after reset", {35'd0, drive}, 36'd0);
    chk("R11", "rdata after reset", rdata, '0);

    gwr(1, 36'h1_2345_6789, "R3");
    rd(1, "R6");
    bwr(1, 36'hF_EDCB_A987, 4'b1010, "R2");        // lanes 0 and 2
    rd(1, "R2");
    step(0, 1, 0, 0, 0, 4'b0101, 2, 36'hA_5A5A_5A5A, "R3"); // global over byte selects
    rd(2, "R3");
    bwr(2, 36'h0_FFFF_0000, 4'hF, "R4");           // byte enable, no lanes
    rd(2, "R4");
    gwr(3, 36'h3_3333_3333, "R6");
    bwr(3, 36'hC_CCCC_CCCC, 4'b0101, "R2");        // lanes 1 and 3
    rd(3, "R2");
    step(1, 1, 0, 0, 1, 4'hF, 1, 36'hD_DDDD_DDDD, "R1");
    step(0, 0, 0, 0, 1, 4'hF, 1, 36'hD_DDDD_DDDD, "R1");
    step(0, 1, 1, 0, 1, 4'hF, 1, 36'hD_DDDD_DDDD, "R1");
    rd(1, "R1");
    rd(2, "R7");                                   // in flight at deselect
    idle("R7");
    idle("R8");                                    // first clock of next read
    rd(1, "R8");
    rd(2, "R5");
    rd(1, "R5");
    oe_probe();
    gwr(4, 36'h4_4444_4444, "R10");
    rd(4, "R6");
    idle("R12");
    gwr(5, 36'h5_5555_5555, "R12");
    idle("R12");
    bwr(5, 36'h7_7777_7777, 4'b1110, "R12");
    rd(5, "R12");
    idle("R7");
    idle("R12");
    idle("R12");
    repeat (3) @(negedge clk);
    chk("R5", "scoreboard drained", 36'(sb.size()), 36'd0);
    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end
endmodule